// File: doc/BRIEF.md
# T1-to-E1 Receive Elastic Slip Buffer

The block takes bytes recovered from a 24-channel line frame (one framing byte followed by 24 channel bytes, 25 bytes per frame) in the line clock domain. It replays them on a 32-slot system highway in an independent system clock domain. A small dual-clock store sits between the two sides. The write position crosses to the system side in Gray code through a two-stage synchronizer. The read side decides, slot by slot, whether the slot carries a stored byte or the idle byte 0xFF.

A mode input picks one of three elastic depths or a bypass path. A second input picks one of two channel-to-slot maps. When the two clocks drift apart, the read side detects that it is about to catch up with the writer or fall too far behind. It then performs a controlled slip: it moves its read position to half the current depth behind the writer, and it raises a one-cycle pulse that tells whether data was repeated or dropped.

The write side counts one byte per `w_en` cycle. The system side treats each `rclk` cycle as one slot. The system side counts slots from the cycle in which `r_fs` is high. `buf_mode` and `tmap_sel` are changed only while both resets are asserted.

Top module: `eb_top`

## Requirements
- R1: Bytes presented with `w_en` high are discarded until the first one that also has `w_fs` high; that byte is the first byte stored.
- R2: With `tmap_sel`=1 the slot in which `r_fs` is high is slot 0, and slots count up by one per `rclk` cycle; slot 0 carries the framing byte, slots 1 to 24 carry channels 1 to 24 in order, and slots 25 to 31 are idle.
- R3: With `tmap_sel`=0 slots 4, 8, 12, 16, 20, 24 and 28 are idle; every other slot, slot 0 included, carries the next stored byte.
- R4: In the three buffered modes an idle slot outputs 0xFF on `r_data`.
- R5: After reset `r_data` is 0xFF and `slip_pulse` is 0. Data slots keep outputting 0xFF until the synchronized fill reaches half the selected depth. The first data byte output is then the first stored byte.
- R6: When bytes are written at the rate the slot map reads them, no slip occurs, and successive data slots carry successive stored bytes.
- R7: When a data slot finds at most one unread byte (or the reader ahead of the writer), a slip occurs with `slip_rep`=1: earlier data is read again.
- R8: When a data slot finds more unread bytes than the selected depth, a slip occurs with `slip_rep`=0: data is skipped.
- R9: `buf_mode` 00 selects a depth of 50 bytes, 01 a depth of 25 bytes and 10 a depth of 12 bytes. On a slip the byte output is the one lying half the depth (25, 12 or 6 bytes) behind the synchronized write position.
- R10: With `buf_mode`=11 (bypass), `r_data` shows in every cycle the most recently written byte seen through the synchronizer. No slot is idle, `r_fs` has no effect, and `slip_pulse` stays 0.
- R11: `slip_pulse` is high for exactly one `rclk` cycle per slip, and is never high in two successive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side clock |
| wrst | input | 1 | Line-side synchronous reset, active high |
| w_fs | input | 1 | Marks the framing byte of a line frame |
| w_en | input | 1 | A line byte is present on `w_byte` |
| w_byte | input | 8 | Line byte |
| rclk | input | 1 | System-side clock, one slot per cycle |
| rrst | input | 1 | System-side synchronous reset, active high |
| r_fs | input | 1 | System frame start; this cycle is slot 0 |
| buf_mode | input | 2 | 00 two-frame, 01 one-frame, 10 short, 11 bypass |
| tmap_sel | input | 1 | 1 contiguous map, 0 spread map |
| r_data | output | 8 | System slot byte, registered |
| slip_pulse | output | 1 | One-cycle slip indication |
| slip_rep | output | 1 | With `slip_pulse`: 1 repeated, 0 deleted |

## Verification
The hardest situation to reach from the ports is a slip at a known distance in each direction and in each depth. That condition needs the fill to drift slowly past a threshold that the reader only sees through a synchronizer several cycles late.

The bench runs both clocks at the same period with a fixed phase offset. It sets the byte rate only through the pattern of `w_en`: a pattern matched to the spread map holds the fill steady, writing every cycle drives it towards overrun, and writing every other cycle drains it towards underrun. Because each stored byte equals its own write index, every data slot shows which stored byte was read. After a slip, that index is compared with the bench's own write count to check the half-depth distance.

// File: rtl/eb_pkg.sv
package eb_pkg;

    localparam int DW       = 8;
    localparam int CHANNELS = 24;
    localparam int SLOTS    = 32;
    localparam int FRAME_B  = CHANNELS + 1;
    localparam int MAX_SIZE = 2 * FRAME_B;
    localparam int PW       = $clog2(MAX_SIZE) + 1;
    localparam int SW       = $clog2(SLOTS);
    localparam int DEPTH    = 2 ** PW;

    typedef logic [DW-1:0] byte_t;
    typedef logic [PW-1:0] ptr_t;
    typedef logic [SW-1:0] slot_t;

    localparam byte_t IDLE = '1;

    typedef enum logic [1:0] {
        BM_TWO    = 2'b00,
        BM_ONE    = 2'b01,
        BM_SHORT  = 2'b10,
        BM_BYPASS = 2'b11
    } bmode_e;

    typedef struct packed {
        byte_t data;
        logic  slip;
        logic  rep;
    } rd_out_t;

    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t from_gray(ptr_t g);
        ptr_t b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // elastic depth in bytes for each buffered mode
    function automatic int buf_size(bmode_e m);
        case (m)
            BM_TWO:   return MAX_SIZE;
            BM_ONE:   return FRAME_B;
            BM_SHORT: return FRAME_B / 2;
            default:  return 0;
        endcase
    endfunction

    // 1 when the slot carries a stored byte under the chosen map
    function automatic logic slot_carries(slot_t s, logic contig);
        if (s == '0)
            return 1'b1;
        if (contig)
            return int'(s) <= CHANNELS;
        return s[1:0] != 2'b00;
    endfunction

endpackage

// File: rtl/eb_sync.sv
module eb_sync
    import eb_pkg::*;
#(
    parameter int W      = PW,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[i] <= '0;
                else     st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side
    import eb_pkg::*;
(
    input  logic  wclk,
    input  logic  wrst,
    input  logic  fs,
    input  logic  en,
    input  byte_t din,
    output logic  we,
    output ptr_t  waddr,
    output byte_t wdata,
    output ptr_t  wgray
);
    logic armed;
    ptr_t wptr;

    // storing starts with the first framing byte
    assign we    = en && (armed || fs);
    assign waddr = wptr;
    assign wdata = din;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            armed <= 1'b0;
            wptr  <= '0;
            wgray <= '0;
        end else begin
            if (en && fs)
                armed <= 1'b1;
            if (we) begin
                wptr  <= wptr + 1'b1;
                wgray <= to_gray(wptr + 1'b1);
            end
        end
    end
endmodule

// File: rtl/eb_store.sv
module eb_store
    import eb_pkg::*;
(
    input  logic  wclk,
    input  logic  we,
    input  ptr_t  waddr,
    input  byte_t wdata,
    input  ptr_t  raddr,
    output byte_t rdata
);
    byte_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eb_slot_ctr.sv
module eb_slot_ctr
    import eb_pkg::*;
(
    input  logic  rclk,
    input  logic  rrst,
    input  logic  fs,
    output slot_t slot_now
);
    slot_t slot_q;

    always_comb slot_now = fs ? '0 : slot_q;

    always_ff @(posedge rclk) begin
        if (rrst) slot_q <= '0;
        else      slot_q <= slot_now + 1'b1;
    end
endmodule

// File: rtl/eb_top.sv
module eb_top
    import eb_pkg::*;
(
    input  logic       wclk,
    input  logic       wrst,
    input  logic       w_fs,
    input  logic       w_en,
    input  logic [7:0] w_byte,
    input  logic       rclk,
    input  logic       rrst,
    input  logic       r_fs,
    input  logic [1:0] buf_mode,
    input  logic       tmap_sel,
    output logic [7:0] r_data,
    output logic       slip_pulse,
    output logic       slip_rep
);
    bmode_e  mode;
    logic    we;
    ptr_t    waddr, wgray, wsync_g, wsync;
    byte_t   wdata, rd_word;
    slot_t   slot_now;
    logic    equip, byp;
    ptr_t    rptr, rp_sel, raddr, rp_n;
    logic    run, run_n;
    int      size_i, half_i, occ_i;
    logic    under_c, over_c;
    rd_out_t out_q, out_n;

    assign mode = bmode_e'(buf_mode);
    assign byp  = (mode == BM_BYPASS);

    eb_wr_side u_wr (
        .wclk (wclk), .wrst (wrst), .fs (w_fs), .en (w_en), .din (w_byte),
        .we (we), .waddr (waddr), .wdata (wdata), .wgray (wgray)
    );

    eb_store u_mem (
        .wclk (wclk), .we (we), .waddr (waddr), .wdata (wdata),
        .raddr (raddr), .rdata (rd_word)
    );

    eb_sync #(.W(PW), .STAGES(2)) u_sync (
        .clk (rclk), .rst (rrst), .d (wgray), .q (wsync_g)
    );

    eb_slot_ctr u_slot (
        .rclk (rclk), .rrst (rrst), .fs (r_fs), .slot_now (slot_now)
    );

    assign wsync = from_gray(wsync_g);
    assign equip = slot_carries(slot_now, tmap_sel);

    // fill measurement and slip decision
    always_comb begin
        size_i  = buf_size(mode);
        half_i  = size_i / 2;
        occ_i   = int'($signed(wsync - rptr));
        under_c = !byp && run && equip && (occ_i <= 1);
        over_c  = !byp && run && equip && !(occ_i <= 1) && (occ_i > size_i);
        rp_sel  = (under_c || over_c) ? (wsync - ptr_t'(half_i)) : rptr;
        raddr   = byp ? (wsync - 1'b1) : rp_sel;
    end

    // next read state and slot output
    always_comb begin
        run_n = run;
        rp_n  = rptr;
        out_n = '{data: IDLE, slip: 1'b0, rep: 1'b0};
        if (byp) begin
            out_n.data = rd_word;
        end else if (!run) begin
            if (occ_i >= half_i)
                run_n = 1'b1;
        end else if (equip) begin
            out_n.data = rd_word;
            out_n.slip = under_c || over_c;
            out_n.rep  = under_c;
            rp_n       = rp_sel + 1'b1;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rptr  <= '0;
            run   <= 1'b0;
            out_q <= '{data: IDLE, slip: 1'b0, rep: 1'b0};
        end else begin
            rptr  <= rp_n;
            run   <= run_n;
            out_q <= out_n;
        end
    end

    assign r_data     = out_q.data;
    assign slip_pulse = out_q.slip;
    assign slip_rep   = out_q.rep;
endmodule

// File: rtl/eb_chk.sv
module eb_chk
    import eb_pkg::*;
(
    input logic       rclk,
    input logic       rrst,
    input logic [1:0] mode,
    input logic       equip,
    input logic       run,
    input logic       slip,
    input logic [7:0] r_data,
    input ptr_t       wsync,
    input ptr_t       rptr
);
    int half_c;
    always_comb half_c = buf_size(bmode_e'(mode)) / 2;

    // R4: idle slot yields all ones
    a_r4_idle_fill: assert property (@(posedge rclk) disable iff (rrst)
        (mode != BM_BYPASS && !equip) |=> (r_data == 8'hFF));

    // R5: nothing but idle before the fill threshold is met
    a_r5_hold_until_run: assert property (@(posedge rclk) disable iff (rrst)
        (mode != BM_BYPASS && !run) |=> (r_data == 8'hFF && !slip));

    // R9: read position lands half a depth behind the writer
    a_r9_recenter: assert property (@(posedge rclk) disable iff (rrst)
        slip |-> (ptr_t'($past(wsync) - rptr) == ptr_t'(half_c - 1)));

    // R10: bypass never slips
    a_r10_bypass_no_slip: assert property (@(posedge rclk) disable iff (rrst)
        (mode == BM_BYPASS) |-> !slip);

    // R11: single-cycle slip indication
    a_r11_slip_single: assert property (@(posedge rclk) disable iff (rrst)
        slip |=> !slip);
endmodule

bind eb_top eb_chk u_chk (
    .rclk   (rclk),
    .rrst   (rrst),
    .mode   (buf_mode),
    .equip  (equip),
    .run    (run),
    .slip   (slip_pulse),
    .r_data (r_data),
    .wsync  (wsync),
    .rptr   (rptr)
);

// File: tb/tb_eb_top.sv
module tb_eb_top;
    logic       wclk = 1'b0, rclk = 1'b0;
    logic       wrst = 1'b1, rrst = 1'b1;
    logic       w_fs = 1'b0, w_en = 1'b0, r_fs = 1'b0, tmap_sel = 1'b1;
    logic [7:0] w_byte = '0;
    logic [1:0] buf_mode = 2'b00;
    logic [7:0] r_data;
    logic       slip_pulse, slip_rep;

    eb_top dut (.*);

    // 125 MHz system clock, line clock same period, phase shifted
    always #4 rclk = ~rclk;
    initial begin
        #3;
        forever #4 wclk = ~wclk;
    end

    int total = 0, bad = 0;
    bit done = 0;

    // test configuration and reference state
    int  t_half, t_kind, t_rate;   // kind 0 none, 1 repeat, 2 delete
    bit  t_byp;
    bit  wact = 0, ract = 0;
    int  wc, wk, pre, rcyc, redges, prev, slips;
    bit  barmed, started, last_slip;
    int  s_last;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit ref_carries(int s, bit contig);
        if (s == 0) return 1'b1;
        if (contig) return s <= 24;
        return (s % 4) != 0;
    endfunction

    function automatic bit wr_pattern(int k, int rate);
        case (rate)
            0: return ref_carries(k % 32, 1'b0);
            1: return 1'b1;
            default: return (k % 2) == 0;
        endcase
    endfunction

    // line-side driver: byte value = its own write index
    always @(negedge wclk) begin
        if (!wact) begin
            w_en = 1'b0; w_fs = 1'b0;
        end else begin
            bit en;
            en = wr_pattern(wk, t_rate);
            wk++;
            w_en = en; w_fs = 1'b0;
            if (en) begin
                if (pre < 3) begin
                    pre++;
                    w_byte = 8'hA5;   // R1: must never be stored
                end else begin
                    if (!barmed) begin
                        w_fs = 1'b1; barmed = 1'b1;
                    end else if (wc % 25 == 0) begin
                        w_fs = 1'b1;
                    end
                    w_byte = 8'(wc);
                    wc++;
                end
            end
        end
    end

    task automatic check_slot(input int s);
        int v, d;
        v = int'(r_data);
        if (t_byp) begin
            if (wc > 8) begin
                d = (wc - 1 - v) & 255;
                chk(d <= 6, "R10 bypass latest byte distance", d, 0);
            end
            chk(!slip_pulse, "R10 no slip in bypass", slip_pulse, 0);
            return;
        end
        if (last_slip)
            chk(!slip_pulse, "R11 slip pulse one cycle", slip_pulse, 0);
        last_slip = slip_pulse;
        if (!ref_carries(s, tmap_sel)) begin
            chk(v == 8'hFF, tmap_sel ? "R2 R4 idle slot" : "R3 R4 idle slot", v, 255);
            chk(!slip_pulse, "R11 no slip in idle slot", slip_pulse, 0);
        end else if (!started) begin
            if (v == 8'hFF && !slip_pulse) begin
                chk(1'b1, "R5 idle while filling", v, 255);
            end else begin
                chk(v == 0, "R1 R5 first byte is first stored", v, 0);
                chk(wc >= t_half && wc <= t_half + 14, "R5 fill at start", wc, t_half);
                started = 1'b1;
                prev = v;
            end
        end else if (slip_pulse) begin
            slips++;
            if (t_kind == 0)
                chk(1'b0, "R6 unexpected slip", 1, 0);
            else if (t_kind == 1)
                chk(slip_rep == 1'b1, "R7 slip repeats", slip_rep, 1);
            else
                chk(slip_rep == 1'b0, "R8 slip deletes", slip_rep, 0);
            d = (wc - v) & 255;
            chk(d >= t_half && d <= t_half + 6, "R9 recenter distance", d, t_half);
            prev = v;
        end else begin
            chk(v == ((prev + 1) & 255), "R6 consecutive bytes", v, (prev + 1) & 255);
            prev = v;
        end
    endtask

    // system-side reference model, compared every cycle
    always @(negedge rclk) begin
        if (ract) begin
            if (redges > 0) check_slot(s_last);
            s_last = rcyc % 32;
            r_fs = t_byp ? ((rcyc % 7) == 3) : (s_last == 0);
            rcyc++;
            redges++;
        end
    end

    task automatic run_test(input logic [1:0] m, input bit contig, input int rate,
                            input int kind, input int cycles);
        @(posedge rclk); #1;
        ract = 0; wact = 0;
        rrst = 1'b1; wrst = 1'b1; r_fs = 1'b0;
        buf_mode = m; tmap_sel = contig;
        t_byp  = (m == 2'b11);
        t_half = (m == 2'b00) ? 25 : (m == 2'b01) ? 12 : 6;
        t_kind = kind; t_rate = rate;
        repeat (4) @(posedge rclk);
        #1;
        chk(r_data == 8'hFF, "R5 reset data", r_data, 255);
        chk(slip_pulse == 1'b0, "R5 reset slip", slip_pulse, 0);
        wc = 0; wk = 0; pre = 0; barmed = 0;
        rcyc = 0; redges = 0; prev = 0; slips = 0; started = 0; last_slip = 0;
        rrst = 1'b0; wrst = 1'b0;
        ract = 1; wact = 1;
        repeat (cycles) @(posedge rclk);
        #1;
        ract = 0; wact = 0;
        if (!t_byp) begin
            chk(started, "R5 data started", started, 1);
            if (kind == 0) chk(slips == 0, "R6 no slips at matched rate", slips, 0);
            if (kind == 1) chk(slips > 0, "R7 underrun slips seen", slips, 1);
            if (kind == 2) chk(slips > 0, "R8 overrun slips seen", slips, 1);
        end
    endtask

    initial begin
        run_test(2'b00, 1'b1, 0, 0, 4000);  // R2 R6 two-frame, contiguous map
        run_test(2'b01, 1'b0, 0, 0, 3000);  // R3 R6 one-frame, spread map
        run_test(2'b10, 1'b0, 0, 0, 3000);  // R6 short, spread map
        run_test(2'b00, 1'b0, 1, 2, 3000);  // R8 R9 overrun, two-frame
        run_test(2'b10, 1'b0, 2, 1, 3000);  // R7 R9 underrun, short
        run_test(2'b01, 1'b1, 2, 1, 3000);  // R7 R9 underrun, one-frame
        run_test(2'b01, 1'b0, 1, 2, 3000);  // R8 R9 overrun, one-frame
        run_test(2'b11, 1'b0, 0, 0, 1000);  // R10 bypass
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule